// File: doc/BRIEF.md
# Two-Phase Bus Access Timeout Monitor

This block guards one master's use of a shared backplane bus. It runs two watchdogs one after the other. The first measures how long the master waits between raising its bus request and receiving the grant. The second measures how long a data transfer keeps either of its two data strobes active. If either window runs past its programmed limit, the block raises a one-cycle bus-error pulse so the master can abort. It also records which of the two phases expired in a sticky status bit.

A free-running prescaler turns the system clock into a fine tick, nominally 1 µs. The fine tick is divided again into a coarse tick, nominally 1 ms. The transfer watchdog counts fine ticks and the arbitration watchdog counts coarse ticks. Each watchdog reads its limit from a small configuration register, and each can be switched off for debug. When the responder's acknowledge arrives, the block passes it back to the master as a one-cycle acknowledge pulse. The acknowledge also ends the transfer watchdog for that access.

Top module: `bto_monitor`

## Requirements
- R1: After reset, bus_err, xfer_ack and status are 0. The configuration resets to transfer select 2 (256 fine ticks), with the arbitration watchdog enabled at select 3 (32 coarse ticks).
- R2: A fine tick occurs at every CLK_PER_US-th clock edge after reset, counting the first edge after reset as edge 1. A coarse tick occurs at every (CLK_PER_US*US_PER_MS)-th edge. Both run freely, whatever the bus activity.
- R3: The arbitration phase is active while bus_req=1 and bus_grant=0. Its limit is set by config bits [3:2]: 0 gives 1, 1 gives 4, 2 gives 16 and 3 gives 32 coarse ticks. Config bit 4 enables it (1 = enabled).
- R4: The transfer phase is active while either strobe bit is 1. Its limit is set by config bits [1:0]: 0 gives 8, 1 gives 64 and 2 gives 256 fine ticks, and 3 disables it.
- R5: A phase expires at the edge where it counts its Nth tick since it became active, N being its limit. bus_err is 1 for exactly the one cycle after that edge. A phase fires at most once per activation.
- R6: On expiry, status bit 0 (arbitration) or status bit 1 (transfer) is set and stays set. A config write to address 1 clears each status bit whose data bit is 1, and leaves the other bits alone.
- R7: A rising dtack during the transfer phase gives a one-cycle xfer_ack and stops the transfer watchdog for that access. If dtack is sampled on the same edge as the expiry, no error and no status bit result.
- R8: If bus_grant is sampled on the same edge as the arbitration expiry, no error and no status bit result.
- R9: When a phase goes inactive for even one edge, its count returns to zero, so the next activation gets a full window.
- R10: A disabled watchdog never raises bus_err, however long its phase stays active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Master requests the bus |
| bus_grant | input | 1 | Bus mastership granted |
| strobe | input | 2 | Data strobes, active high |
| dtack | input | 1 | Responder acknowledge |
| cfg_wr | input | 1 | Register write enable |
| cfg_addr | input | 1 | 0 = configuration, 1 = status clear |
| cfg_wdata | input | 5 | Write data |
| bus_err | output | 1 | One-cycle timeout pulse |
| xfer_ack | output | 1 | One-cycle acknowledge to the master |
| status | output | 2 | Sticky expiry flags: bit 0 arbitration, bit 1 transfer |

## Verification
A count that is off by one, or a prescaler out of phase, moves the bus_err pulse by one clock edge or by a whole tick period. The bench therefore predicts the exact edge for every limit setting and checks the cycles on either side of it. A counter that fails to clear between accesses shows up as an early error on the second access of a back-to-back pair. A lost acknowledge or grant priority shows up as a stray pulse, or as a status bit set on the race edge itself.

// File: rtl/bto_pkg.sv
package bto_pkg;
  typedef enum logic [1:0] {
    XF_SHORT = 2'd0,
    XF_MID   = 2'd1,
    XF_LONG  = 2'd2,
    XF_OFF   = 2'd3
  } xfer_sel_e;

  typedef struct packed {
    logic       arb_en;
    logic [1:0] arb_sel;
    xfer_sel_e  xfer_sel;
  } cfg_t;

  localparam int unsigned ST_ARB  = 0;
  localparam int unsigned ST_XFER = 1;
  localparam logic [4:0]  CFG_RESET = 5'b1_11_10;
endpackage

// File: rtl/bto_prescale.sv
module bto_prescale #(
  parameter int unsigned DIV_FINE   = 200,
  parameter int unsigned DIV_COARSE = 1000
) (
  input  logic clk,
  input  logic rst,
  output logic fine_tick,
  output logic coarse_tick
);
  localparam int unsigned FW = (DIV_FINE > 1) ? $clog2(DIV_FINE) : 1;
  localparam int unsigned CW = (DIV_COARSE > 1) ? $clog2(DIV_COARSE) : 1;

  logic [FW-1:0] fcnt;
  logic [CW-1:0] ccnt;

  assign fine_tick   = (fcnt == FW'(DIV_FINE - 1));
  assign coarse_tick = fine_tick && (ccnt == CW'(DIV_COARSE - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      fcnt <= '0;
      ccnt <= '0;
    end else begin
      fcnt <= fine_tick ? '0 : fcnt + 1'b1;
      if (fine_tick) ccnt <= coarse_tick ? '0 : ccnt + 1'b1;
    end
  end

  generate
    if (DIV_FINE > 1) begin : g_fine_chk
      assert_fine_spacing_R2: assert property (@(posedge clk) disable iff (rst)
        fine_tick |=> !fine_tick);
    end
  endgenerate
endmodule

// File: rtl/bto_phase_timer.sv
module bto_phase_timer #(
  parameter int unsigned CW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          active,
  input  logic          tick,
  input  logic          en,
  input  logic [CW-1:0] limit,
  input  logic          stop,
  output logic          expire
);
  logic [CW-1:0] cnt;
  logic          done;

  assign expire = active && en && !done && !stop && tick && (cnt == limit - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      if (stop || expire) done <= 1'b1;
      if (tick && en && !done) cnt <= cnt + 1'b1;
    end
  end

  assert_idle_clears_R9: assert property (@(posedge clk) disable iff (rst)
    !active |=> (cnt == '0));
endmodule

// File: rtl/bto_regs.sv
module bto_regs
  import bto_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr,
  input  logic       addr,
  input  logic [4:0] wdata,
  input  logic       set_arb,
  input  logic       set_xfer,
  output cfg_t       cfg,
  output logic [1:0] status
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg    <= cfg_t'(CFG_RESET);
      status <= '0;
    end else begin
      if (wr && !addr) cfg <= cfg_t'(wdata);
      status[ST_ARB]  <= set_arb  | (status[ST_ARB]  & ~(wr & addr & wdata[ST_ARB]));
      status[ST_XFER] <= set_xfer | (status[ST_XFER] & ~(wr & addr & wdata[ST_XFER]));
    end
  end

  assert_arb_flag_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (status[ST_ARB] && !(wr && addr && wdata[ST_ARB])) |=> status[ST_ARB]);
  assert_xfer_flag_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (status[ST_XFER] && !(wr && addr && wdata[ST_XFER])) |=> status[ST_XFER]);
endmodule

// File: rtl/bto_monitor.sv
module bto_monitor
  import bto_pkg::*;
#(
  parameter int unsigned CLK_PER_US = 200,
  parameter int unsigned US_PER_MS  = 1000,
  parameter int unsigned XFER_T0    = 8,
  parameter int unsigned XFER_T1    = 64,
  parameter int unsigned XFER_T2    = 256,
  parameter int unsigned ARB_T0     = 1,
  parameter int unsigned ARB_T1     = 4,
  parameter int unsigned ARB_T2     = 16,
  parameter int unsigned ARB_T3     = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_req,
  input  logic       bus_grant,
  input  logic [1:0] strobe,
  input  logic       dtack,
  input  logic       cfg_wr,
  input  logic       cfg_addr,
  input  logic [4:0] cfg_wdata,
  output logic       bus_err,
  output logic       xfer_ack,
  output logic [1:0] status
);
  localparam int unsigned XCW = $clog2(XFER_T2 + 1);
  localparam int unsigned ACW = $clog2(ARB_T3 + 1);

  logic fine_tick, coarse_tick;
  logic arb_active, xfer_active, arb_exp, xfer_exp, dtack_q;
  logic [XCW-1:0] xfer_limit;
  logic [ACW-1:0] arb_limit;
  cfg_t cfg;

  assign arb_active  = bus_req && !bus_grant;
  assign xfer_active = |strobe;

  always_comb begin
    case (cfg.xfer_sel)
      XF_SHORT: xfer_limit = XCW'(XFER_T0);
      XF_MID:   xfer_limit = XCW'(XFER_T1);
      default:  xfer_limit = XCW'(XFER_T2);
    endcase
    case (cfg.arb_sel)
      2'd0:    arb_limit = ACW'(ARB_T0);
      2'd1:    arb_limit = ACW'(ARB_T1);
      2'd2:    arb_limit = ACW'(ARB_T2);
      default: arb_limit = ACW'(ARB_T3);
    endcase
  end

  bto_prescale #(.DIV_FINE(CLK_PER_US), .DIV_COARSE(US_PER_MS)) u_pre (
    .clk(clk), .rst(rst), .fine_tick(fine_tick), .coarse_tick(coarse_tick));

  bto_phase_timer #(.CW(ACW)) u_arb (
    .clk(clk), .rst(rst), .active(arb_active), .tick(coarse_tick),
    .en(cfg.arb_en), .limit(arb_limit), .stop(1'b0), .expire(arb_exp));

  bto_phase_timer #(.CW(XCW)) u_xfer (
    .clk(clk), .rst(rst), .active(xfer_active), .tick(fine_tick),
    .en(cfg.xfer_sel != XF_OFF), .limit(xfer_limit), .stop(dtack),
    .expire(xfer_exp));

  bto_regs u_regs (
    .clk(clk), .rst(rst), .wr(cfg_wr), .addr(cfg_addr), .wdata(cfg_wdata),
    .set_arb(arb_exp), .set_xfer(xfer_exp), .cfg(cfg), .status(status));

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_err  <= 1'b0;
      xfer_ack <= 1'b0;
      dtack_q  <= 1'b0;
    end else begin
      bus_err  <= arb_exp | xfer_exp;
      xfer_ack <= dtack & ~dtack_q & xfer_active;
      dtack_q  <= dtack;
    end
  end

  assert_quiet_after_reset_R1: assert property (@(posedge clk)
    rst |=> (!bus_err && !xfer_ack));
  assert_err_flags_status_R5: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> (status != 2'b00));
  assert_ack_beats_timeout_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(status[ST_XFER]) |-> !xfer_ack);
  assert_grant_beats_timeout_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(status[ST_ARB]) |-> $past(bus_req && !bus_grant));
endmodule

// File: tb/test_bto_monitor.sv
`timescale 1ns/1ps
module test_bto_monitor;
  localparam int PF = 2;
  localparam int PC = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_req = 0, bus_grant = 0, dtack = 0, cfg_wr = 0, cfg_addr = 0;
  logic [1:0] strobe = 0;
  logic [4:0] cfg_wdata = 0;
  logic bus_err, xfer_ack;
  logic [1:0] status;
  int ecount, n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) if (rst) ecount <= 0; else ecount <= ecount + 1;

  bto_monitor #(.CLK_PER_US(PF), .US_PER_MS(2)) i_bto_monitor (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_grant(bus_grant),
    .strobe(strobe), .dtack(dtack), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .bus_err(bus_err), .xfer_ack(xfer_ack),
    .status(status));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [4:0] d);
    @(negedge clk); cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_wr = 0;
  endtask

  // Runs one phase to expiry (lim>0) or for a long stretch (lim==0 = disabled).
  task automatic run_phase(input bit arb, input int lim, input logic [1:0] ds, input string tag);
    int per = arb ? PC : PF;
    int ticks = 0;
    int early = 0;
    int bit_no = arb ? 0 : 1;
    @(negedge clk); if (arb) bus_req = 1; else strobe = ds;
    for (int i = 0; i < (lim == 0 ? 40 * per : lim * per + 2); i++) begin
      @(negedge clk);
      if (ecount % per == 0) ticks++;
      if (lim != 0 && ticks == lim) begin
        check(bus_err == 1, {tag, " R2 R5 pulse at limit edge"}, bus_err, 1);
        break;
      end
      if (bus_err) early++;
    end
    check(early == 0, {tag, " R5 R10 no early error"}, early, 0);
    if (lim != 0) begin
      early = 0;
      for (int i = 0; i < 3 * per; i++) begin
        @(negedge clk); if (bus_err) early++;
      end
      check(early == 0, {tag, " R5 single pulse"}, early, 0);
    end
    bus_req = 0; strobe = 0;
    @(negedge clk);
    check(status == (lim != 0 ? (2'b01 << bit_no) : 2'b00), {tag, " R6 status flag"},
          status, lim != 0 ? (1 << bit_no) : 0);
    wr(1'b1, 5'b00011);
    check(status == 0, {tag, " R6 status cleared"}, status, 0);
  endtask

  // Raises the terminating input on the edge where expiry would happen.
  task automatic race(input bit arb, input int lim, input string tag);
    int per = arb ? PC : PF;
    int ticks = 0;
    int errs = 0;
    @(negedge clk); if (arb) bus_req = 1; else strobe = 2'b01;
    forever begin
      @(negedge clk);
      if (ecount % per == 0) ticks++;
      if (bus_err) errs++;
      if (ticks == lim - 1 && (ecount + 1) % per == 0) break;
    end
    if (arb) bus_grant = 1; else dtack = 1;
    @(negedge clk);
    if (!arb) check(xfer_ack == 1, {tag, " R7 ack pulse"}, xfer_ack, 1);
    for (int i = 0; i < (lim + 2) * per; i++) begin
      @(negedge clk); if (bus_err) errs++;
    end
    check(errs == 0, {tag, " no error on race edge"}, errs, 0);
    check(status == 0, {tag, " no status on race edge"}, status, 0);
    bus_req = 0; bus_grant = 0; strobe = 0; dtack = 0;
    @(negedge clk);
  endtask

  initial begin
    int errs;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(bus_err == 0 && xfer_ack == 0, "R1 outputs idle", bus_err, 0);
    check(status == 0, "R1 status idle", status, 0);
    // R1 defaults: transfer 256 fine ticks, arbitration 32 coarse ticks.
    run_phase(0, 256, 2'b10, "R1 R4 default xfer");
    run_phase(1, 32, 2'b00, "R1 R3 default arb");
    // Sweep all transfer selects, alternating strobes.
    wr(0, 5'b1_11_00); run_phase(0, 8,  2'b01, "R4 sel0");
    wr(0, 5'b1_11_01); run_phase(0, 64, 2'b10, "R4 sel1");
    wr(0, 5'b1_11_10); run_phase(0, 256, 2'b11, "R4 sel2");
    wr(0, 5'b1_11_11); run_phase(0, 0, 2'b01, "R10 xfer off");
    // Sweep all arbitration selects, then disabled.
    for (int s = 0; s < 4; s++) begin
      wr(0, {1'b1, 2'(s), 2'b00});
      run_phase(1, (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 16 : 32, 2'b00, "R3 arb sweep");
    end
    wr(0, 5'b0_00_00); run_phase(1, 0, 2'b00, "R10 arb off");
    // R7 and R8: acknowledge or grant on the expiry edge wins.
    wr(0, 5'b1_01_00);
    race(0, 8, "R7");
    race(1, 4, "R8");
    // R7: early acknowledge gives one pulse and stops the watchdog.
    @(negedge clk); strobe = 2'b01;
    repeat (3) @(negedge clk);
    dtack = 1;
    @(negedge clk); check(xfer_ack == 1, "R7 early ack pulse", xfer_ack, 1);
    @(negedge clk); check(xfer_ack == 0, "R7 ack one cycle", xfer_ack, 0);
    errs = 0;
    for (int i = 0; i < 10 * PF; i++) begin @(negedge clk); if (bus_err) errs++; end
    check(errs == 0 && status == 0, "R7 stopped after ack", errs, 0);
    strobe = 0; dtack = 0;
    // R9: partial access, one idle edge, then a full window.
    @(negedge clk); strobe = 2'b01;
    repeat (5 * PF) @(negedge clk);
    strobe = 0;
    run_phase(0, 8, 2'b01, "R9 back-to-back");
    // R6: clearing one flag leaves the other.
    run_phase(0, 8, 2'b01, "R6 prep");
    @(negedge clk); strobe = 2'b01;
    repeat (8 * PF + 2) @(negedge clk);
    strobe = 0;
    wr(1'b1, 5'b00001);
    check(status == 2'b10, "R6 selective clear", status, 2);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=0", 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule